// File: doc/BRIEF.md
# Reset Sequencer with Cause Capture

This block collects every reset request of a small processor subsystem and turns them into a single system reset. The requests are:

- power-on
- the external reset pin, classified as arriving in normal run or in sleep
- a watchdog timeout during run
- brown-out
- a software reset instruction
- a trap conflict lockup
- an illegal opcode or uninitialized address pointer

Any request raises the system reset at once, in the same cycle. Release is synchronous and always lands on the first quarter (Q1) of a free-running four-phase instruction cycle. The phase is exported so that integration logic can line up with it.

The external pin is active low and is only ever read here. It passes a two-stage synchronizer and then a counting filter, so short pulses are dropped. Power-on and brown-out hold reset for a fixed bias settling time of about 10 us, followed by a power-up timeout chosen by two configuration bits. The other sources hold reset for the bias time only.

All timing derives from a reference clock frequency parameter. One sticky flag per cause records why the last resets happened. Software clears flags by writing zeros. A power-on leaves only its own flag set and latches the clock-source configuration. A watchdog timeout while asleep is a wake-up, not a reset.

Top module: `reset_sequencer`

## Requirements
- R1: Each internal source raises `sys_rst_o` combinationally in the cycle it is high, and sets its flag bit. The bit positions are: watchdog-in-run bit 3, brown-out bit 4, software reset bit 5, trap conflict bit 6, illegal opcode/pointer bit 7.
- R2: A low on `xrst_n_i` lasting fewer than `FILT_CYC` clock cycles has no effect on `sys_rst_o` or on the flags. A low held longer causes a reset that sets bit 1 when `sleep_i` is 0 and bit 2 when `sleep_i` is 1.
- R3: After `por_i` falls, `sys_rst_o` falls at clock edge m after the first edge with `por_i` low. m is the smallest multiple of 4 with m >= B + P + 1, where B = ceil(CLK_HZ/100000) and P is the power-up timeout in cycles.
- R4: The `pwrt_cfg_i` code gives P: 0 is none, 1 is CLK_HZ/250 (4 ms), 2 is CLK_HZ/1000*16 (16 ms) and 3 is CLK_HZ/1000*64 (64 ms).
- R5: `phase_o` is 0 (Q1) while `por_i` is high and then steps by one each cycle modulo 4. `sys_rst_o` only falls in a cycle where `phase_o` is 0.
- R6: A watchdog timeout while `sleep_i` is 1 does not raise `sys_rst_o` and sets no flag. `wake_o` is high in the following cycle.
- R7: Flags are sticky. A cycle with `flag_wr_i` high ANDs the flags with `flag_wdata_i`, so written zeros clear bits. A source that fires in the same cycle still sets its bit.
- R8: While `por_i` is high, the flags read 0x01 (power-on, bit 0) and `clk_src_o` follows `clk_src_cfg_i`. After that, `clk_src_o` stays fixed until the next power-on.
- R9: A new request that arrives while reset is still held restarts the delay. Release then comes between B+2 and B+5 edges after the edge that sampled the new request.
- R10: After a one-cycle pulse of brown-out or any other internal source, with `pwrt_cfg_i` at 0, release comes between B+2 and B+5 edges after the sampling edge. Brown-out also adds P when `pwrt_cfg_i` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_i | input | 1 | Power-on event, active high, also the block's synchronous reset |
| xrst_n_i | input | 1 | External reset pin, active low, asynchronous |
| sleep_i | input | 1 | Device is in sleep |
| wdt_to_i | input | 1 | Watchdog timeout |
| bor_i | input | 1 | Brown-out detected |
| swrst_i | input | 1 | Software reset instruction |
| trap_i | input | 1 | Trap conflict lockup |
| iop_i | input | 1 | Illegal opcode or uninitialized pointer use |
| pwrt_cfg_i | input | 2 | Power-up timeout selection |
| clk_src_cfg_i | input | CSW | Clock-source configuration |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 8 | Flag write mask (0 clears) |
| sys_rst_o | output | 1 | System reset, active high |
| phase_o | output | 2 | Instruction phase, 0 = Q1 |
| flags_o | output | 8 | Sticky reset-cause flags |
| clk_src_o | output | CSW | Latched clock-source selection |
| wake_o | output | 1 | Watchdog wake-up pulse |

## Verification
Reset assertion is combinational, so the bench drives a source on a falling clock edge and reads `sys_rst_o` one time unit later in the same cycle. `wake_o` and the flags are registered and are read at the next falling edge. Release timing is counted in rising edges from the edge that first samples the stimulus. For power-on, the bench computes the exact edge as the first multiple of 4 at or above B+P+1. For other sources, the phase at the stimulus is not fixed, so the bench checks the window B+2 to B+5 and requires `phase_o` to be 0 at the release. The restart case places the second request so that a sequencer that failed to restart would release before that window.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int NCAUSE = 8;

    localparam int C_POR      = 0;
    localparam int C_XRST_RUN = 1;
    localparam int C_XRST_SLP = 2;
    localparam int C_WDT      = 3;
    localparam int C_BOR      = 4;
    localparam int C_SWR      = 5;
    localparam int C_TRAP     = 6;
    localparam int C_IOP      = 7;

    localparam logic [1:0] PH_Q1 = 2'd0;
    localparam logic [1:0] PH_Q4 = 2'd3;

    typedef logic [NCAUSE-1:0] cause_vec_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_BIAS  = 2'd1,
        ST_PWRT  = 2'd2,
        ST_ALIGN = 2'd3
    } seq_state_e;

    // bias settle time of 10 us, rounded up to whole cycles
    function automatic int bias_cycles(input int hz);
        return (hz + 99999) / 100000;
    endfunction

    // power-up timeout length in cycles for a configuration code
    function automatic int pwrt_cycles(input logic [1:0] sel, input int hz);
        case (sel)
            2'd0:    return 0;
            2'd1:    return hz / 250;
            2'd2:    return (hz / 1000) * 16;
            default: return (hz / 1000) * 64;
        endcase
    endfunction

endpackage

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
    parameter int FILT_CYC = 8
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pin_n_i,
    output logic hit_o
);
    localparam int W = $clog2(FILT_CYC + 1);

    logic [1:0]   sync_q;
    logic [W-1:0] low_cnt_q;
    logic         hit_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q    <= 2'b11;
            low_cnt_q <= '0;
            hit_q     <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_n_i};
            if (sync_q[1]) begin
                low_cnt_q <= '0;
                hit_q     <= 1'b0;
            end else if (low_cnt_q == W'(FILT_CYC - 1)) begin
                hit_q <= 1'b1;
            end else begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign hit_o = hit_q;
endmodule

// File: rtl/rstseq_phase_gen.sv
module rstseq_phase_gen (
    input  logic       clk_i,
    input  logic       rst_i,
    output logic [1:0] phase_o
);
    logic [1:0] phase_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) phase_q <= rstseq_pkg::PH_Q1;
        else       phase_q <= phase_q + 2'd1;
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/rstseq_delay_fsm.sv
module rstseq_delay_fsm
    import rstseq_pkg::*;
#(
    parameter int CLK_HZ = 1_000_000
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       req_i,
    input  logic       long_i,
    input  logic [1:0] pwrt_cfg_i,
    input  logic [1:0] phase_i,
    output logic       busy_o
);
    localparam int BIAS_CYC = bias_cycles(CLK_HZ);
    localparam int MAX_CYC  = (pwrt_cycles(2'd3, CLK_HZ) > BIAS_CYC) ?
                              pwrt_cycles(2'd3, CLK_HZ) : BIAS_CYC;
    localparam int CW       = $clog2(MAX_CYC + 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          long_q;
    logic [CW-1:0] pwrt_tgt;

    always_comb begin
        pwrt_tgt = CW'(pwrt_cycles(pwrt_cfg_i, CLK_HZ));
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_BIAS;
            cnt_q   <= '0;
            long_q  <= 1'b1;
        end else if (req_i) begin
            state_q <= ST_BIAS;
            cnt_q   <= '0;
            long_q  <= long_i | ((state_q != ST_RUN) & long_q);
        end else begin
            case (state_q)
                ST_BIAS: begin
                    if (cnt_q == CW'(BIAS_CYC - 1)) begin
                        cnt_q   <= '0;
                        state_q <= (long_q && pwrt_tgt != '0) ? ST_PWRT : ST_ALIGN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PWRT: begin
                    if (cnt_q == pwrt_tgt - 1'b1) begin
                        cnt_q   <= '0;
                        state_q <= ST_ALIGN;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_ALIGN: begin
                    if (phase_i == PH_Q4) begin
                        state_q <= ST_RUN;
                        long_q  <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (state_q != ST_RUN);
endmodule

// File: rtl/rstseq_cause_flags.sv
module rstseq_cause_flags
    import rstseq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  cause_vec_t set_i,
    input  logic       wr_i,
    input  cause_vec_t wdata_i,
    output cause_vec_t flags_o
);
    cause_vec_t flags_q;
    cause_vec_t kept;

    always_comb begin
        kept = wr_i ? (flags_q & wdata_i) : flags_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            flags_q        <= '0;
            flags_q[C_POR] <= 1'b1;
        end else begin
            flags_q <= kept | set_i;
        end
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int CLK_HZ   = 1_000_000,
    parameter int FILT_CYC = 8,
    parameter int CSW      = 3
) (
    input  logic             clk_i,
    input  logic             por_i,
    input  logic             xrst_n_i,
    input  logic             sleep_i,
    input  logic             wdt_to_i,
    input  logic             bor_i,
    input  logic             swrst_i,
    input  logic             trap_i,
    input  logic             iop_i,
    input  logic [1:0]       pwrt_cfg_i,
    input  logic [CSW-1:0]   clk_src_cfg_i,
    input  logic             flag_wr_i,
    input  logic [NCAUSE-1:0] flag_wdata_i,
    output logic             sys_rst_o,
    output logic [1:0]       phase_o,
    output logic [NCAUSE-1:0] flags_o,
    output logic [CSW-1:0]   clk_src_o,
    output logic             wake_o
);
    logic       xrst_hit;
    logic       busy;
    logic       any_req;
    cause_vec_t set_vec;
    logic [1:0] phase;
    logic [CSW-1:0] clk_src_q;
    logic       wake_q;

    rstseq_pin_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk_i   (clk_i),
        .rst_i   (por_i),
        .pin_n_i (xrst_n_i),
        .hit_o   (xrst_hit)
    );

    rstseq_phase_gen u_phase (
        .clk_i   (clk_i),
        .rst_i   (por_i),
        .phase_o (phase)
    );

    always_comb begin
        set_vec             = '0;
        set_vec[C_XRST_RUN] = xrst_hit & ~sleep_i;
        set_vec[C_XRST_SLP] = xrst_hit & sleep_i;
        set_vec[C_WDT]      = wdt_to_i & ~sleep_i;
        set_vec[C_BOR]      = bor_i;
        set_vec[C_SWR]      = swrst_i;
        set_vec[C_TRAP]     = trap_i;
        set_vec[C_IOP]      = iop_i;
        any_req             = |set_vec;
    end

    rstseq_delay_fsm #(.CLK_HZ(CLK_HZ)) u_fsm (
        .clk_i      (clk_i),
        .rst_i      (por_i),
        .req_i      (any_req),
        .long_i     (bor_i),
        .pwrt_cfg_i (pwrt_cfg_i),
        .phase_i    (phase),
        .busy_o     (busy)
    );

    rstseq_cause_flags u_flags (
        .clk_i   (clk_i),
        .rst_i   (por_i),
        .set_i   (set_vec),
        .wr_i    (flag_wr_i),
        .wdata_i (flag_wdata_i),
        .flags_o (flags_o)
    );

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            clk_src_q <= clk_src_cfg_i;
            wake_q    <= 1'b0;
        end else begin
            wake_q    <= wdt_to_i & sleep_i;
        end
    end

    assign sys_rst_o = por_i | busy | any_req;
    assign phase_o   = phase;
    assign clk_src_o = clk_src_q;
    assign wake_o    = wake_q;
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk #(
    parameter int CSW = 3
) (
    input logic           clk_i,
    input logic           por_i,
    input logic           sleep_i,
    input logic           wdt_to_i,
    input logic           bor_i,
    input logic           swrst_i,
    input logic           trap_i,
    input logic           iop_i,
    input logic           flag_wr_i,
    input logic           sys_rst_o,
    input logic [1:0]     phase_o,
    input logic [7:0]     flags_o,
    input logic [CSW-1:0] clk_src_o,
    input logic           wake_o
);
    assert_src_raises_rst_R1: assert property (@(posedge clk_i) disable iff (por_i)
        (bor_i | swrst_i | trap_i | iop_i | (wdt_to_i & ~sleep_i)) |-> sys_rst_o);

    assert_phase_steps_R5: assert property (@(posedge clk_i) disable iff (por_i)
        1'b1 |=> (phase_o == $past(phase_o) + 2'd1));

    assert_release_on_q1_R5: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(sys_rst_o) |-> (phase_o == 2'd0));

    assert_sleep_wdt_wakes_R6: assert property (@(posedge clk_i) disable iff (por_i)
        (wdt_to_i & sleep_i) |=> wake_o);

    assert_flags_sticky_R7: assert property (@(posedge clk_i) disable iff (por_i)
        !flag_wr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

    assert_clk_src_held_R8: assert property (@(posedge clk_i) disable iff (por_i)
        1'b1 |=> $stable(clk_src_o));
endmodule

bind reset_sequencer reset_sequencer_chk #(.CSW(CSW)) u_chk (.*);

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb;
    localparam int CLK_HZ = 500_000;
    localparam int FILT   = 8;
    localparam int CSW    = 3;
    localparam int B      = (CLK_HZ + 99999) / 100000;

    // table: {wdt, bor, swr, trap, iop} pulse and expected flag byte
    localparam int NV = 5;
    localparam logic [4:0] VEC_SRC  [NV] = '{5'b10000, 5'b01000, 5'b00100, 5'b00010, 5'b00001};
    localparam logic [7:0] VEC_FLAG [NV] = '{8'h08, 8'h10, 8'h20, 8'h40, 8'h80};

    logic clk = 1'b0;
    logic por, xrst_n, sleep, wdt, bor, swr, trap, iop, fwr;
    logic [1:0] pcfg;
    logic [CSW-1:0] ccfg;
    logic [7:0] fwd;
    logic sys_rst, wake;
    logic [1:0] phase;
    logic [7:0] flags;
    logic [CSW-1:0] csrc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    reset_sequencer #(.CLK_HZ(CLK_HZ), .FILT_CYC(FILT), .CSW(CSW)) u_dut (
        .clk_i(clk), .por_i(por), .xrst_n_i(xrst_n), .sleep_i(sleep),
        .wdt_to_i(wdt), .bor_i(bor), .swrst_i(swr), .trap_i(trap), .iop_i(iop),
        .pwrt_cfg_i(pcfg), .clk_src_cfg_i(ccfg), .flag_wr_i(fwr), .flag_wdata_i(fwd),
        .sys_rst_o(sys_rst), .phase_o(phase), .flags_o(flags), .clk_src_o(csrc),
        .wake_o(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_rel(input int start, output int n);
        n = start;
        while (sys_rst && n < 40000) begin
            @(posedge clk); n++; @(negedge clk);
        end
    endtask

    function automatic int pcyc(input logic [1:0] s);
        case (s)
            2'd0: return 0;
            2'd1: return CLK_HZ / 250;
            2'd2: return (CLK_HZ / 1000) * 16;
            default: return (CLK_HZ / 1000) * 64;
        endcase
    endfunction

    task automatic clear_flags();
        @(negedge clk); fwr = 1'b1; fwd = 8'h00;
        @(negedge clk); fwr = 1'b0; fwd = 8'hFF;
    endtask

    task automatic do_por(input logic [1:0] sel, input logic [CSW-1:0] cs);
        int n, expm;
        @(negedge clk); por = 1'b1; pcfg = sel; ccfg = cs;
        repeat (3) @(negedge clk);
        chk("R8 flags in power-on", 32'(flags), 32'h01);
        chk("R8 clk_src follows cfg", 32'(csrc), 32'(cs));
        chk("R5 phase Q1 in power-on", 32'(phase), 32'd0);
        por = 1'b0;
        wait_rel(0, n);
        expm = ((B + pcyc(sel) + 1 + 3) / 4) * 4;
        chk("R3/R4 power-on release edge", 32'(n), 32'(expm));
        chk("R5 phase at power-on release", 32'(phase), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        por = 1'b1; xrst_n = 1'b1; sleep = 1'b0; wdt = 1'b0; bor = 1'b0;
        swr = 1'b0; trap = 1'b0; iop = 1'b0; fwr = 1'b0; fwd = 8'hFF;
        pcfg = 2'd0; ccfg = 3'd5;
        repeat (3) @(negedge clk);
        // reset state
        chk("R5 reset sys_rst", 32'(sys_rst), 32'd1);
        chk("R6 reset wake", 32'(wake), 32'd0);

        do_por(2'd0, 3'd5);
        @(negedge clk); ccfg = 3'd2;
        repeat (3) @(negedge clk);
        chk("R8 clk_src held after power-on", 32'(csrc), 32'd5);

        // table of internal sources
        for (int i = 0; i < NV; i++) begin
            clear_flags();
            {wdt, bor, swr, trap, iop} = VEC_SRC[i];
            #1;
            chk("R1 immediate reset", 32'(sys_rst), 32'd1);
            @(posedge clk); @(negedge clk);
            {wdt, bor, swr, trap, iop} = 5'b0;
            wait_rel(1, n);
            chk("R10 source release window", 32'(n >= B + 2 && n <= B + 5), 32'd1);
            chk("R5 phase at release", 32'(phase), 32'd0);
            chk("R1 flag bit", 32'(flags), 32'(VEC_FLAG[i]));
        end
        chk("R8 clk_src held across resets", 32'(csrc), 32'd5);

        // R2 short pin pulse ignored
        clear_flags();
        xrst_n = 1'b0; repeat (3) @(negedge clk); xrst_n = 1'b1;
        n = 0;
        repeat (12) begin @(negedge clk); if (sys_rst) n++; end
        chk("R2 short pulse no reset", 32'(n), 32'd0);
        chk("R2 short pulse no flag", 32'(flags), 32'h00);
        // long pulse in run
        xrst_n = 1'b0; repeat (FILT + 6) @(negedge clk);
        chk("R2 long pulse resets", 32'(sys_rst), 32'd1);
        xrst_n = 1'b1;
        wait_rel(0, n);
        chk("R2 run pin flag bit1", 32'(flags), 32'h02);
        // long pulse in sleep
        clear_flags(); sleep = 1'b1;
        xrst_n = 1'b0; repeat (FILT + 6) @(negedge clk); xrst_n = 1'b1;
        wait_rel(0, n);
        chk("R2 sleep pin flag bit2", 32'(flags), 32'h04);

        // R6 watchdog in sleep
        clear_flags();
        wdt = 1'b1; #1;
        chk("R6 no immediate reset", 32'(sys_rst), 32'd0);
        @(negedge clk); wdt = 1'b0;
        chk("R6 wake pulse", 32'(wake), 32'd1);
        chk("R6 no reset after wake", 32'(sys_rst), 32'd0);
        @(negedge clk);
        chk("R6 no flag", 32'(flags), 32'h00);
        sleep = 1'b0;

        // R9 restart
        swr = 1'b1; @(posedge clk); @(negedge clk); swr = 1'b0;
        repeat (3) @(negedge clk);
        trap = 1'b1; @(posedge clk); @(negedge clk); trap = 1'b0;
        wait_rel(1, n);
        chk("R9 restart release window", 32'(n >= B + 2 && n <= B + 5), 32'd1);
        chk("R9 both flags", 32'(flags), 32'h60);

        // R7 selective clear, and set beats clear
        @(negedge clk); fwr = 1'b1; fwd = 8'hBF;
        @(negedge clk); fwr = 1'b0; fwd = 8'hFF;
        chk("R7 write zero clears bit6", 32'(flags), 32'h20);
        fwr = 1'b1; fwd = 8'h00; iop = 1'b1;
        @(negedge clk); fwr = 1'b0; fwd = 8'hFF; iop = 1'b0;
        chk("R7 set wins over clear", 32'(flags), 32'h80);
        wait_rel(0, n);
        repeat (4) @(negedge clk);
        chk("R7 sticky without write", 32'(flags), 32'h80);

        // R10 brown-out with timeout
        @(negedge clk); pcfg = 2'd1; bor = 1'b1;
        @(posedge clk); @(negedge clk); bor = 1'b0;
        wait_rel(1, n);
        chk("R10 brown-out adds timeout", 32'(n >= B + pcyc(2'd1) + 2 && n <= B + pcyc(2'd1) + 5), 32'd1);

        // remaining power-up codes
        do_por(2'd1, 3'd1);
        do_por(2'd2, 3'd6);
        do_por(2'd3, 3'd3);
        chk("R8 flags only power-on", 32'(flags), 32'h01);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule